// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Controller

This block watches a bank of general-purpose input pins and turns selected pin activity into interrupts. Every pin has four independent trigger conditions (rising edge, falling edge, high level and low level), each with its own enable register. Pins are brought into the clock domain by a two-flop synchroniser. Edges are found by comparing each synchronised sample with the one taken in the cycle before.

Edge events are latched as sticky pending bits that software clears by writing 1. A separate direction record shows whether the last enabled edge on a pin was rising or falling. Level conditions are not latched: their status follows the pin for as long as the condition holds. All status bits are ORed into a single interrupt line. Software reaches the block through a plain 32-bit register bus with a word index, write strobes and combinational read data. The bus carries no data stream, so it has no valid/ready handshake.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all four enable registers, the status register and the edge-direction register read 0, and `irq_o` is low.
- R2: The rising-enable register (index 0) and the falling-enable register (index 1) read back the last value written to them.
- R3: A 0-to-1 change on a pin whose rising enable (index 0) is set makes that pin's bit in the status register (index 4) read 1 after the third rising clock edge that follows the change, and not before. The bit stays 1 after the pin returns low.
- R4: A 1-to-0 change on a pin whose falling enable (index 1) is set sets its status bit in the same way. The edge-direction register (index 5) holds, for each pin, the direction of its most recent enabled edge: 1 for rising, 0 for falling.
- R5: Writing the status register clears each edge-pending bit whose write-data bit is 1 and leaves bits written 0 unchanged. An enabled edge that arrives in the same cycle as its clear leaves the bit set.
- R6: With the high-level enable (index 2) set, a pin's status bit reads 1 from the second clock edge after the pin goes high, and 0 from the second edge after it goes low. The low-level enable (index 3) behaves the same with the polarity reversed. Writing 1 to the status bit does not clear a level condition that still holds.
- R7: High-level and low-level enables are never both set for one pin. A write that would set one of them while the other is already set leaves that bit 0, and the other bits of the same write take effect.
- R8: `irq_o` is 1 exactly when at least one status bit reads 1.
- R9: Edges on a pin whose matching edge enable is clear change neither its status bit nor its edge-direction bit.
- R10: Index 6 reads the synchronised pin levels. Writes to indices 5, 6 and 7 change nothing, and index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | Asynchronous pin levels |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken with bus_sel at the clock edge |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the synchroniser latency. A design that skips a stage or adds one raises status a cycle early or late, and the bench samples on both sides of the expected edge. It clears a pending edge in the same cycle as a new event on that pin. A design where the clear wins loses that interrupt. It sends a one-cycle pulse with both edge enables set, so a design that misses either edge shows up in the pending bit or in the recorded direction. It also writes conflicting level enables, writes 1 to the status bit of an active level condition, and writes to read-only indices. A wrong design there would end up with both polarities enabled, drop a live level interrupt, or corrupt its records. A randomised phase compares every register read and the interrupt line against the model on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_DW = 32;
  localparam int BUS_AW = 3;

  typedef enum logic [BUS_AW-1:0] {
    REG_RISE_EN  = 3'd0,
    REG_FALL_EN  = 3'd1,
    REG_HIGH_EN  = 3'd2,
    REG_LOW_EN   = 3'd3,
    REG_STATUS   = 3'd4,
    REG_EDGE_DIR = 3'd5,
    REG_PIN_LVL  = 3'd6,
    REG_SPARE    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_i,
  output logic [NPINS-1:0] sync_o
);
  logic [NPINS-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge_det.sv
module gpio_irq_edge_det #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs import gpio_irq_pkg::*; #(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NPINS-1:0]  high_en_o,
  output logic [NPINS-1:0]  low_en_o,
  output logic [NPINS-1:0]  clr_mask_o
);
  logic [NPINS-1:0] rise_q, fall_q, high_q, low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else if (wr_en_i) begin
      case (reg_idx_e'(addr_i))
        REG_RISE_EN: rise_q <= wdata_i;
        REG_FALL_EN: fall_q <= wdata_i;
        // a level enable never overrides the opposite polarity already set
        REG_HIGH_EN: high_q <= wdata_i & ~low_q;
        REG_LOW_EN:  low_q  <= wdata_i & ~high_q;
        default: ;
      endcase
    end
  end

  assign rise_en_o  = rise_q;
  assign fall_en_o  = fall_q;
  assign high_en_o  = high_q;
  assign low_en_o   = low_q;
  assign clr_mask_o = (wr_en_i && reg_idx_e'(addr_i) == REG_STATUS) ? wdata_i : '0;
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  input  logic [NPINS-1:0] high_en_i,
  input  logic [NPINS-1:0] low_en_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] pend_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic ev_rise, ev_fall, lvl_hit;
    logic pend_q, dir_q;

    assign ev_rise = rise_i[g] & rise_en_i[g];
    assign ev_fall = fall_i[g] & fall_en_i[g];
    assign lvl_hit = (high_en_i[g] & lvl_i[g]) | (low_en_i[g] & ~lvl_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        dir_q  <= 1'b0;
      end else begin
        // a new event takes priority over a clear in the same cycle
        pend_q <= ev_rise | ev_fall | (pend_q & ~clr_mask_i[g]);
        if (ev_rise)      dir_q <= 1'b1;
        else if (ev_fall) dir_q <= 1'b0;
      end
    end

    assign pend_o[g]   = pend_q;
    assign dir_o[g]    = dir_q;
    assign status_o[g] = pend_q | lvl_hit;
  end

  assign irq_o = |status_o;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl import gpio_irq_pkg::*; #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_o
);
  logic [NPINS-1:0] sync_lvl, rise_ev, fall_ev;
  logic [NPINS-1:0] rise_en, fall_en, high_en, low_en, clr_mask;
  logic [NPINS-1:0] edge_pend, edge_dir, status;
  logic             wr_en;

  assign wr_en = bus_sel & bus_wr;

  gpio_irq_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(sync_lvl)
  );

  gpio_irq_edge_det #(.NPINS(NPINS)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  gpio_irq_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(bus_addr),
    .wdata_i(bus_wdata[NPINS-1:0]),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .high_en_o(high_en),
    .low_en_o(low_en), .clr_mask_o(clr_mask)
  );

  gpio_irq_status #(.NPINS(NPINS)) stat_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl), .rise_i(rise_ev), .fall_i(fall_ev),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .high_en_i(high_en), .low_en_i(low_en),
    .clr_mask_i(clr_mask), .pend_o(edge_pend), .dir_o(edge_dir),
    .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (reg_idx_e'(bus_addr))
      REG_RISE_EN:  bus_rdata[NPINS-1:0] = rise_en;
      REG_FALL_EN:  bus_rdata[NPINS-1:0] = fall_en;
      REG_HIGH_EN:  bus_rdata[NPINS-1:0] = high_en;
      REG_LOW_EN:   bus_rdata[NPINS-1:0] = low_en;
      REG_STATUS:   bus_rdata[NPINS-1:0] = status;
      REG_EDGE_DIR: bus_rdata[NPINS-1:0] = edge_dir;
      REG_PIN_LVL:  bus_rdata[NPINS-1:0] = sync_lvl;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [NPINS-1:0] sync_lvl,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en,
  input logic [NPINS-1:0] high_en,
  input logic [NPINS-1:0] low_en,
  input logic [NPINS-1:0] edge_pend,
  input logic [NPINS-1:0] clr_mask
);
  p_level_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (high_en & low_en) == '0);

  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((edge_pend & $past(edge_pend)) == $past(edge_pend)));

  p_edge_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_pend & ~$past(edge_pend)) & ~($past(rise_en) | $past(fall_en))) == '0);

  p_high_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(high_en & sync_lvl)) |-> irq_o);

  p_low_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(low_en & ~sync_lvl)) |-> irq_o);

  p_quiet_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pend == '0 && (high_en & sync_lvl) == '0 && (low_en & ~sync_lvl) == '0)
      |-> !irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .sync_lvl(sync_lvl),
  .rise_en(rise_en), .fall_en(fall_en), .high_en(high_en), .low_en(low_en),
  .edge_pend(edge_pend), .clr_mask(clr_mask)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // behavioural reference: pin history as a queue, per-pin flags as words
  logic [31:0] hist[$];
  logic [31:0] m_rise, m_fall, m_high, m_low, m_pend, m_dir;

  function automatic logic [31:0] m_lvl();
    return hist[1];  // level seen two clocks after the pin
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] l = m_lvl();
    return m_pend | (m_high & l) | (m_low & ~l);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_rise;
      3'd1: return m_fall;
      3'd2: return m_high;
      3'd3: return m_low;
      3'd4: return m_status();
      3'd5: return m_dir;
      3'd6: return m_lvl();
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {32'h0, 32'h0, 32'h0};
      m_rise = 0; m_fall = 0; m_high = 0; m_low = 0; m_pend = 0; m_dir = 0;
    end else begin
      logic [31:0] cur, old, up, dn, clr;
      cur = hist[1]; old = hist[2];
      up  = cur & ~old & m_rise;
      dn  = ~cur & old & m_fall;
      clr = (sel && wr && addr == 3'd4) ? wdata : 32'h0;
      m_pend = (m_pend & ~clr) | up | dn;
      m_dir  = (m_dir | up) & ~dn;
      if (sel && wr) begin
        case (addr)
          3'd0: m_rise = wdata;
          3'd1: m_fall = wdata;
          3'd2: m_high = wdata & ~m_low;
          3'd3: m_low  = wdata & ~m_high;
          default: ;
        endcase
      end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare the model on every clock, after outputs settle
  always begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      string t;
      case (addr)
        3'd0, 3'd1: t = "R2";
        3'd2, 3'd3: t = "R7";
        3'd4: t = "R5";
        3'd5: t = "R4";
        default: t = "R10";
      endcase
      chk("R8 irq", {31'h0, irq}, {31'h0, |m_status()});
      chk(t, rdata, m_read(addr));
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R10 pin level, read-only indices, R9 unenabled edges
    @(negedge clk); pin = 32'h0000_00A5;
    wait_clk(3);
    rd(3'd6, v); chk("R10 pin level", v, 32'h0000_00A5);
    wr_reg(3'd6, 32'hFFFF_FFFF); wr_reg(3'd5, 32'hFFFF_FFFF); wr_reg(3'd7, 32'h1234_5678);
    rd(3'd6, v); chk("R10 level after write", v, 32'h0000_00A5);
    rd(3'd5, v); chk("R10 dir after write", v, 32'h0);
    rd(3'd7, v); chk("R10 spare", v, 32'h0);
    rd(3'd4, v); chk("R9 status no enable", v, 32'h0);
    @(negedge clk); pin = 32'h0;
    wait_clk(4);

    // R2 readback
    wr_reg(3'd0, 32'h0000_00F1); rd(3'd0, v); chk("R2 rise readback", v, 32'h0000_00F1);
    wr_reg(3'd1, 32'h8000_0302); rd(3'd1, v); chk("R2 fall readback", v, 32'h8000_0302);
    wr_reg(3'd0, 32'h1); wr_reg(3'd1, 32'h2);

    // R3 rising latency and stickiness
    rd(3'd4, v);
    @(negedge clk); pin[0] = 1;
    wait_clk(2); chk("R3 not yet", {31'h0, rdata[0]}, 32'h0);
    wait_clk(1); chk("R3 set", {31'h0, rdata[0]}, 32'h1);
    @(negedge clk); pin[0] = 0;
    wait_clk(5); chk("R3 sticky", {31'h0, rdata[0]}, 32'h1);
    rd(3'd5, v); chk("R4 dir rising", {31'h0, v[0]}, 32'h1);

    // R5 write-0 no effect, write-1 clears
    wr_reg(3'd4, 32'h0); rd(3'd4, v); chk("R5 write0 keeps", {31'h0, v[0]}, 32'h1);
    wr_reg(3'd4, 32'h1); rd(3'd4, v); chk("R5 write1 clears", {31'h0, v[0]}, 32'h0);

    // R5 clear and event in the same cycle
    @(negedge clk); pin[0] = 1;
    @(negedge clk);
    @(negedge clk); sel = 1; wr = 1; addr = 3'd4; wdata = 32'h1;
    @(negedge clk); sel = 0; wr = 0; #1;
    chk("R5 event beats clear", {31'h0, rdata[0]}, 32'h1);
    wr_reg(3'd4, 32'h1); @(negedge clk); pin[0] = 0; wait_clk(4);

    // R9 rising on fall-only pin, R4 falling
    @(negedge clk); pin[1] = 1; wait_clk(4);
    rd(3'd4, v); chk("R9 rise ignored", {31'h0, v[1]}, 32'h0);
    @(negedge clk); pin[1] = 0; wait_clk(4);
    rd(3'd4, v); chk("R4 fall set", {31'h0, v[1]}, 32'h1);
    rd(3'd5, v); chk("R4 dir falling", {31'h0, v[1]}, 32'h0);

    // R4 one-cycle pulse with both enables: last direction is falling
    wr_reg(3'd0, 32'h21); wr_reg(3'd1, 32'h22);
    @(negedge clk); pin[5] = 1; @(negedge clk); pin[5] = 0;
    wait_clk(5);
    rd(3'd4, v); chk("R4 pulse pending", {31'h0, v[5]}, 32'h1);
    rd(3'd5, v); chk("R4 pulse dir", {31'h0, v[5]}, 32'h0);
    wr_reg(3'd4, 32'hFFFF_FFFF);

    // R6 high level
    wr_reg(3'd2, 32'h4);
    rd(3'd4, v);
    @(negedge clk); pin[2] = 1;
    wait_clk(1); chk("R6 high not yet", {31'h0, rdata[2]}, 32'h0);
    wait_clk(1); chk("R6 high set", {31'h0, rdata[2]}, 32'h1);
    chk("R8 irq high", {31'h0, irq}, 32'h1);
    wr_reg(3'd4, 32'h4); rd(3'd4, v); chk("R6 clear ignored while high", {31'h0, v[2]}, 32'h1);
    @(negedge clk); pin[2] = 0;
    wait_clk(2); chk("R6 high drops", {31'h0, rdata[2]}, 32'h0);
    chk("R8 irq low", {31'h0, irq}, 32'h0);

    // R6 low level
    wr_reg(3'd3, 32'h10); rd(3'd4, v); chk("R6 low set", {31'h0, v[4]}, 32'h1);
    @(negedge clk); pin[4] = 1;
    wait_clk(2); chk("R6 low drops", {31'h0, rdata[4]}, 32'h0);

    // R7 conflicting level enables
    wr_reg(3'd3, 32'h1C); rd(3'd3, v); chk("R7 low keeps high", v, 32'h18);
    wr_reg(3'd2, 32'h0C); rd(3'd2, v); chk("R7 high keeps low", v, 32'h04);

    // randomised phase, checked every clock by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      pin = pin ^ ($urandom & $urandom & $urandom);
      addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) begin
        sel = 1; wr = 1; wdata = $urandom;
      end else begin
        sel = 0; wr = 0;
      end
    end
    @(negedge clk); sel = 0; wr = 0;
    wait_clk(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule